// File: doc/BRIEF.md
# Flash Write Unlock Controller

This block guards writes into program memory. Software fills a small holding buffer one byte at a time through a data port whose pointer steps forward after each write. It then opens a write window by writing two fixed key bytes, 55h and then AAh, to a key port that stores nothing. The very next bus write must be to the control register with the start bit set. The start bit only takes effect if writing was already enabled and the target bits select program flash.

Once a write is launched, the controller raises a stall output that holds the processor for a fixed number of clock cycles, set by a parameter. In the last stalled cycle it presents the whole holding-buffer image on a commit port together with a one-cycle done pulse, and the start bit clears itself. There are two reset inputs. A system reset (master or watchdog) that lands while the stall is active aborts the write and sets an error flag. A system reset does not clear that flag. Only power-on reset or an explicit write-one-to-clear from software clears it.

Top module: `flash_unlock_ctrl`

## Requirements
- R1: The start bit takes effect only if it is set by a control-register write (address 0) that directly follows a write of 55h and then a write of AAh to the key port (address 1). Keys in any other order or value launch nothing.
- R2: Start is ignored unless the enable bit (control bit 1) was already 1 before the start write and stays 1 in the written value. An ignored start reads back as 0 in control bit 0.
- R3: Any bus write that falls between the key bytes, or between the second key and the start write, returns the key sequencer to idle.
- R4: After a launching write, the stall output is high for exactly PROG_CYCLES consecutive cycles, starting at the clock edge that captures the write.
- R5: The done output and the commit-valid output pulse for exactly one cycle, in the last stalled cycle. From the next cycle, the stall is low and control bit 0 reads 0.
- R6: The commit image carries the byte written in position i to the holding port (address 2) at bits [8i+7:8i]. The pointer wraps modulo HOLD_BYTES and returns to 0 after a commit and after any reset.
- R7: A system reset taken while the stall is high ends the stall, sets the error bit (control bit 2) and produces no commit.
- R8: Start takes effect only if the written value has memory-select (bit 3) = 1 and config-select (bit 4) = 0.
- R9: The error bit keeps its value through a system reset. It is cleared by power-on reset or by writing 1 to control bit 2.
- R10: Bus writes made while the stall is high have no effect on the buffer, the key sequencer or the control bits.
- R11: A read of the control register returns {3'b0, config-select, memory-select, error, enable, start}. After reset it reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| sys_rst_n | input | 1 | Master/watchdog reset, sampled on the clock, active low; keeps the error bit |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address: 0 control, 1 key, 2 holding data |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| cpu_stall | output | 1 | High while programming is in progress |
| prog_done | output | 1 | One-cycle pulse when programming completes |
| commit_valid | output | 1 | Commit strobe to the array |
| commit_data | output | HOLD_BYTES*DATA_W | Holding-buffer image being committed |

## Verification
The bench builds the block with PROG_CYCLES = 12 and HOLD_BYTES = 4. These values keep every stall window short enough to count cycle by cycle. They also let a run of five holding writes show the pointer wrapping within one buffer load. A window of twelve cycles leaves room to inject a system reset part-way through a write and then recover, and to repeat that with power-on reset.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;

   localparam int REG_CTRL = 0;
   localparam int REG_KEY  = 1;
   localparam int REG_HOLD = 2;

   localparam int BIT_START = 0;
   localparam int BIT_WEN   = 1;
   localparam int BIT_ERR   = 2;
   localparam int BIT_MSEL  = 3;
   localparam int BIT_CSEL  = 4;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_HALF  = 2'd1,
      KS_ARMED = 2'd2
   } key_state_e;

endpackage

// File: rtl/fu_key_seq.sv
module fu_key_seq
   import flash_unlock_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              armed
);

   localparam logic [ADDR_W-1:0] KEY_ADDR = ADDR_W'(REG_KEY);

   key_state_e state_q, state_d;

   always_comb begin
      state_d = KS_IDLE;
      unique case (state_q)
         KS_IDLE:  if (wr_addr == KEY_ADDR && wr_data == KEY_FIRST)  state_d = KS_HALF;
         KS_HALF:  if (wr_addr == KEY_ADDR && wr_data == KEY_SECOND) state_d = KS_ARMED;
         default:  state_d = KS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          state_q <= KS_IDLE;
      else if (!sys_rst_n) state_q <= KS_IDLE;
      else if (wr_en)      state_q <= state_d;
   end

   assign armed = (state_q == KS_ARMED);

   assert_armed_after_half_R1: assert property (@(posedge clk) disable iff (!por_n)
      $rose(armed) |-> $past(state_q == KS_HALF));

   assert_armed_single_write_R3: assert property (@(posedge clk) disable iff (!por_n)
      (armed && wr_en) |=> !armed);

endmodule

// File: rtl/fu_prog_timer.sv
module fu_prog_timer #(
   parameter int CYCLES = 64
) (
   input  logic clk,
   input  logic por_n,
   input  logic sys_rst_n,
   input  logic launch,
   output logic busy,
   output logic last
);

   localparam int CNT_W = $clog2(CYCLES);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES - 1);

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("fu_prog_timer: CYCLES must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!sys_rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end else if (launch) begin
         busy_q <= 1'b1;
         cnt_q  <= LOAD;
      end
   end

   assign busy = busy_q;
   assign last = busy_q && (cnt_q == '0);

   assert_busy_holds_R4: assert property (@(posedge clk) disable iff (!por_n)
      (busy && !last && sys_rst_n) |=> busy);

   assert_last_ends_R5: assert property (@(posedge clk) disable iff (!por_n)
      last |=> !busy);

endmodule

// File: rtl/fu_hold_buf.sv
module fu_hold_buf #(
   parameter int BYTES  = 8,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    por_n,
   input  logic                    sys_rst_n,
   input  logic                    wr_en,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    flush,
   output logic [BYTES*DATA_W-1:0] image
);

   localparam int  PTR_W = (BYTES > 1) ? $clog2(BYTES) : 1;
   localparam bit  POW2  = (BYTES > 0) && ((BYTES & (BYTES - 1)) == 0);
   localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(BYTES - 1);

   generate
      if (BYTES < 1) begin : g_bad_bytes
         $error("fu_hold_buf: BYTES must be at least 1");
      end
   endgenerate

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_inc;

   generate
      if (POW2) begin : g_wrap_natural
         assign ptr_inc = ptr_q + 1'b1;
      end else begin : g_wrap_compare
         assign ptr_inc = (ptr_q == PTR_MAX) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          ptr_q <= '0;
      else if (!sys_rst_n) ptr_q <= '0;
      else if (flush)      ptr_q <= '0;
      else if (wr_en)      ptr_q <= (BYTES > 1) ? ptr_inc : '0;
   end

   for (genvar i = 0; i < BYTES; i++) begin : g_slot
      logic [DATA_W-1:0] slot_q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                                  slot_q <= '0;
         else if (!sys_rst_n)                         slot_q <= '0;
         else if (wr_en && ptr_q == PTR_W'(i))        slot_q <= wr_data;
      end
      assign image[i*DATA_W +: DATA_W] = slot_q;
   end

   assert_ptr_home_after_flush_R6: assert property (@(posedge clk) disable iff (!por_n)
      flush |=> (ptr_q == '0));

endmodule

// File: rtl/flash_unlock_ctrl.sv
module flash_unlock_ctrl
   import flash_unlock_pkg::*;
#(
   parameter int PROG_CYCLES = 64,
   parameter int HOLD_BYTES  = 8,
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 8
) (
   input  logic                         clk,
   input  logic                         por_n,
   input  logic                         sys_rst_n,
   input  logic                         bus_we,
   input  logic [ADDR_W-1:0]            bus_addr,
   input  logic [DATA_W-1:0]            bus_wdata,
   output logic [DATA_W-1:0]            bus_rdata,
   output logic                         cpu_stall,
   output logic                         prog_done,
   output logic                         commit_valid,
   output logic [HOLD_BYTES*DATA_W-1:0] commit_data
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
   localparam logic [ADDR_W-1:0] A_HOLD = ADDR_W'(REG_HOLD);

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("flash_unlock_ctrl: DATA_W must be 8 to carry the key bytes");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("flash_unlock_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   logic busy, last, armed;
   logic bus_ok, ctrl_wr, hold_wr, launch;
   logic wen_q, msel_q, csel_q, err_q;

   assign bus_ok  = bus_we && !busy;
   assign ctrl_wr = bus_ok && (bus_addr == A_CTRL);
   assign hold_wr = bus_ok && (bus_addr == A_HOLD);
   assign launch  = ctrl_wr && armed && wen_q
                    && bus_wdata[BIT_START] && bus_wdata[BIT_WEN]
                    && bus_wdata[BIT_MSEL] && !bus_wdata[BIT_CSEL];

   fu_key_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_key (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .wr_en     (bus_ok),
      .wr_addr   (bus_addr),
      .wr_data   (bus_wdata),
      .armed     (armed)
   );

   fu_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .launch    (launch),
      .busy      (busy),
      .last      (last)
   );

   fu_hold_buf #(.BYTES(HOLD_BYTES), .DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .wr_en     (hold_wr),
      .wr_data   (bus_wdata),
      .flush     (last),
      .image     (commit_data)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wen_q  <= 1'b0;
         msel_q <= 1'b0;
         csel_q <= 1'b0;
      end else if (!sys_rst_n) begin
         wen_q  <= 1'b0;
         msel_q <= 1'b0;
         csel_q <= 1'b0;
      end else if (ctrl_wr) begin
         wen_q  <= bus_wdata[BIT_WEN];
         msel_q <= bus_wdata[BIT_MSEL];
         csel_q <= bus_wdata[BIT_CSEL];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                         err_q <= 1'b0;
      else if (!sys_rst_n && busy)                        err_q <= 1'b1;
      else if (sys_rst_n && ctrl_wr && bus_wdata[BIT_ERR]) err_q <= 1'b0;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL) begin
         bus_rdata[BIT_START] = busy;
         bus_rdata[BIT_WEN]   = wen_q;
         bus_rdata[BIT_ERR]   = err_q;
         bus_rdata[BIT_MSEL]  = msel_q;
         bus_rdata[BIT_CSEL]  = csel_q;
      end
   end

   assign cpu_stall    = busy;
   assign prog_done    = last;
   assign commit_valid = last;

   assert_launch_after_key_R1: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cpu_stall) |-> $past(armed && wen_q));

   assert_done_single_R5: assert property (@(posedge clk) disable iff (!por_n)
      prog_done |=> !prog_done && !cpu_stall);

   assert_err_cause_R7: assert property (@(posedge clk) disable iff (!por_n)
      $rose(err_q) |-> $past(!sys_rst_n && cpu_stall));

   assert_err_kept_R9: assert property (@(posedge clk) disable iff (!por_n)
      ($past(err_q) && !$past(sys_rst_n)) |-> err_q);

endmodule

// File: tb/flash_unlock_ctrl_bench.sv
module flash_unlock_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int PROG       = 12;
   localparam int HB         = 4;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          sys_rst_n = 1'b0;
   logic          bus_we = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic [7:0]    bus_wdata = 8'h00;
   logic [7:0]    bus_rdata;
   logic          cpu_stall, prog_done, commit_valid;
   logic [HB*8-1:0] commit_data;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   bit abort_expected = 1'b0;
   bit prev_commit = 1'b0;
   int stall_run = 0;
   logic [HB*8-1:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_unlock_ctrl #(.PROG_CYCLES(PROG), .HOLD_BYTES(HB), .ADDR_W(2), .DATA_W(8)) u_flash_unlock_ctrl (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cpu_stall(cpu_stall), .prog_done(prog_done),
      .commit_valid(commit_valid), .commit_data(commit_data)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
      bus_addr = a;
      #1;
      chk(bus_rdata == exp, req, bus_rdata, exp);
   endtask

   task automatic keys();
      wr(2'd1, 8'h55);
      wr(2'd1, 8'hAA);
   endtask

   task automatic wait_idle();
      while (cpu_stall) @(negedge clk);
      @(negedge clk);
   endtask

   // Monitor: stall length (R4), commit content (R6), done shape (R5)
   always @(negedge clk) begin
      if (por_n) begin
         if (prev_commit) begin
            chk(!cpu_stall && !prog_done, "R5 done/stall low after commit", {cpu_stall, prog_done}, 0);
         end
         prev_commit = commit_valid;
         if (cpu_stall) stall_run++;
         else if (stall_run != 0) begin
            if (!abort_expected) chk(stall_run == PROG, "R4 stall length", stall_run, PROG);
            stall_run = 0;
         end
         if (commit_valid) begin
            chk(prog_done && cpu_stall, "R5 done in last stall cycle", {prog_done, cpu_stall}, 3);
            if (exp_q.size() == 0) chk(1'b0, "R6 unexpected commit", commit_data, 0);
            else begin
               logic [HB*8-1:0] e;
               e = exp_q.pop_front();
               chk(commit_data == e, "R6 commit image", commit_data, e);
            end
         end
      end else begin
         stall_run = 0;
         prev_commit = 1'b0;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1; sys_rst_n = 1'b1;
      @(negedge clk);

      // R11 reset value
      rd_chk(2'd0, 8'h00, "R11 reset ctrl");
      chk(!cpu_stall, "R11 reset stall", cpu_stall, 0);

      // basic write, R4/R5/R6/R11
      wr(2'd2, 8'h11); wr(2'd2, 8'h22); wr(2'd2, 8'h33); wr(2'd2, 8'h44);
      exp_q.push_back(32'h44332211);
      wr(2'd0, 8'h0A);
      keys();
      wr(2'd0, 8'h0B);
      chk(cpu_stall, "R4 stall after launch", cpu_stall, 1);
      rd_chk(2'd0, 8'h0B, "R11 start reads 1 while busy");
      wait_idle();
      rd_chk(2'd0, 8'h0A, "R5 start self-clears");

      // R10 writes while stalled are ignored
      wr(2'd2, 8'hA1); wr(2'd2, 8'hA2); wr(2'd2, 8'hA3); wr(2'd2, 8'hA4);
      exp_q.push_back(32'hA4A3A2A1);
      keys();
      wr(2'd0, 8'h0B);
      wr(2'd2, 8'hFF); wr(2'd1, 8'h55); wr(2'd1, 8'hAA); wr(2'd0, 8'h1A);
      wait_idle();
      rd_chk(2'd0, 8'h0A, "R10 ctrl unchanged by busy write");
      wr(2'd0, 8'h0B);
      chk(!cpu_stall, "R10 keys during busy not kept", cpu_stall, 0);

      // R1 wrong key order
      wr(2'd1, 8'hAA); wr(2'd1, 8'h55); wr(2'd0, 8'h0B);
      chk(!cpu_stall, "R1 reversed keys ignored", cpu_stall, 0);
      rd_chk(2'd0, 8'h0A, "R1 start reads 0");
      wr(2'd1, 8'h55); wr(2'd1, 8'h5A); wr(2'd0, 8'h0B);
      chk(!cpu_stall, "R1 wrong second key ignored", cpu_stall, 0);

      // R3 interleaved write (buffer byte0 = 77, pointer now 1)
      wr(2'd1, 8'h55); wr(2'd2, 8'h77); wr(2'd1, 8'hAA); wr(2'd0, 8'h0B);
      chk(!cpu_stall, "R3 interleaved write resets keys", cpu_stall, 0);
      keys(); wr(2'd3, 8'h00); wr(2'd0, 8'h0B);
      chk(!cpu_stall, "R3 write before start resets keys", cpu_stall, 0);

      // R2 enable clear
      wr(2'd0, 8'h08); keys(); wr(2'd0, 8'h09);
      chk(!cpu_stall, "R2 enable clear ignored", cpu_stall, 0);
      rd_chk(2'd0, 8'h08, "R2 start reads 0");
      wr(2'd0, 8'h08); keys(); wr(2'd0, 8'h0B);
      chk(!cpu_stall, "R2 enable set in same write ignored", cpu_stall, 0);

      // R8 target select
      wr(2'd0, 8'h0A); keys(); wr(2'd0, 8'h1B);
      chk(!cpu_stall, "R8 config target ignored", cpu_stall, 0);
      rd_chk(2'd0, 8'h1A, "R8 ctrl readback");
      keys(); wr(2'd0, 8'h03);
      chk(!cpu_stall, "R8 memsel clear ignored", cpu_stall, 0);

      // R6 wrap: ptr at 1 -> 88@1 99@2 AA@3 BB@0 CC@1
      wr(2'd2, 8'h88); wr(2'd2, 8'h99); wr(2'd2, 8'hAA); wr(2'd2, 8'hBB); wr(2'd2, 8'hCC);
      exp_q.push_back(32'hAA99CCBB);
      wr(2'd0, 8'h0A); keys(); wr(2'd0, 8'h0B);
      wait_idle();

      // R7 abort by system reset
      wr(2'd2, 8'h01); wr(2'd2, 8'h02); wr(2'd2, 8'h03); wr(2'd2, 8'h04);
      wr(2'd0, 8'h0A); keys(); wr(2'd0, 8'h0B);
      abort_expected = 1'b1;
      repeat (4) @(negedge clk);
      sys_rst_n = 1'b0;
      @(negedge clk);
      sys_rst_n = 1'b1;
      chk(!cpu_stall, "R7 stall ended by reset", cpu_stall, 0);
      rd_chk(2'd0, 8'h04, "R7 error set after abort");
      repeat (PROG) @(negedge clk);
      abort_expected = 1'b0;

      // R9 error survives system reset, W1C, POR
      sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
      rd_chk(2'd0, 8'h04, "R9 error kept over system reset");
      wr(2'd0, 8'h04);
      rd_chk(2'd0, 8'h00, "R9 error write-one-clear");
      wr(2'd0, 8'h0A); keys(); wr(2'd0, 8'h0B);
      abort_expected = 1'b1;
      repeat (3) @(negedge clk);
      sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1;
      rd_chk(2'd0, 8'h04, "R7 second abort sets error");
      abort_expected = 1'b0;
      por_n = 1'b0; @(negedge clk); por_n = 1'b1;
      rd_chk(2'd0, 8'h00, "R9 power-on clears error");

      // R6 pointer reset by reset, normal write afterwards
      wr(2'd2, 8'h05); wr(2'd2, 8'h06); wr(2'd2, 8'h07); wr(2'd2, 8'h08);
      exp_q.push_back(32'h08070605);
      wr(2'd0, 8'h0A); keys(); wr(2'd0, 8'h0B);
      wait_idle();

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 all commits seen", exp_q.size(), 0);
      report();
   end

endmodule